// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Sign Flags

This block is the arithmetic core of a small accumulator machine. It holds the accumulator, a shadow copy of the accumulator, and a three-way sign status. Each operation takes an opcode and an operand and is started with a one-cycle `start` pulse. The unit can load the accumulator, add, subtract, multiply or divide it by the operand, or evaluate a branch condition. It reports completion with a one-cycle `done` pulse.

At the start edge the shadow register takes a copy of the accumulator and the operand is latched. On the following edge the result is written back into the accumulator while the shadow copy supplies the first operand. The sign status records whether the last result was negative, positive or zero. The three conditional branch opcodes are judged against that status.

Immediate and memory forms of an operation behave the same here, because fetching the memory word is done outside the block and the word arrives on the operand port. The store opcode only acknowledges, so that external logic can write `acc_o` to memory. Instruction sequencing and the program counter are also external.

Top module: `acc_alu_core`

## Requirements
- R1: While reset is asserted, and after it is released, `acc_o` is 0, all three flags are 0, and `done_o` and `br_taken_o` are 0.
- R2: A `start_i` seen at a clock edge while the unit is idle is accepted. `done_o` is then high for exactly one cycle, after the second edge from that edge. A `start_i` seen while an operation is in flight is ignored.
- R3: Opcodes 1 and 10 load the operand into the accumulator.
- R4: Opcodes 2 and 6 add the operand to the accumulator, and opcodes 3 and 7 subtract the operand from it. Both wrap modulo 2^32.
- R5: Opcodes 4 and 8 multiply the accumulator by the operand and keep the low 32 bits of the signed product.
- R6: Opcodes 5 and 9 divide the accumulator by the operand as signed numbers, truncating toward zero. The most negative value divided by -1 gives the most negative value. A zero divisor leaves the accumulator unchanged and sets only the zero flag.
- R7: After opcodes 1 to 10, exactly one flag is set. The flag outputs are neg (result < 0), pos (result > 0) and zero (result = 0).
- R8: Opcode 11 (store), opcode 12 (jump) and opcode 0 (no operation) complete with `done_o`. They change neither the accumulator nor the flags.
- R9: `br_taken_o` is high only in the `done_o` cycle. It is set for opcode 12 always, for opcode 13 when neg is set, for opcode 14 when pos is set, and for opcode 15 when zero is set. It is never set for any other opcode.
- R10: `clear_i` at an edge zeroes the accumulator, the shadow copy and the flags. It aborts any operation in flight without a `done_o` pulse, and it takes priority over `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside |
| start_i | input | 1 | Begin an operation with the opcode and operand on this edge |
| clear_i | input | 1 | Synchronous clear of all registers |
| opcode_i | input | 4 | Operation code, 0 to 15 |
| operand_i | input | 32 | Immediate constant or memory word |
| acc_o | output | 32 | Accumulator value |
| flag_neg_o | output | 1 | Last result negative |
| flag_pos_o | output | 1 | Last result positive |
| flag_zero_o | output | 1 | Last result zero |
| done_o | output | 1 | One-cycle completion pulse |
| br_taken_o | output | 1 | Branch condition met, valid with done_o |

## Verification
The bench sweeps every pair drawn from a set of signed values that includes 0, ±1, ±2 and both extremes, through all eight arithmetic opcodes. Each pair is followed by all four branch opcodes and by store and no-operation. Several errors would show up in this sweep. A divider that rounds toward minus infinity would return -4 for -7/2. A divider with no guard would trap or return garbage on the most negative value divided by -1. A design that writes the accumulator on a zero divisor would lose its value. Flags that are treated as unsigned would report the most negative value as positive.

Two further tests target the start and clear behaviour. A second start held during the busy cycle must not replace the running operation. A clear during the execute cycle must leave a zero accumulator and no done pulse.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP  = 4'd0,
    OPC_LDI  = 4'd1,
    OPC_ADDI = 4'd2,
    OPC_SUBI = 4'd3,
    OPC_MULI = 4'd4,
    OPC_DIVI = 4'd5,
    OPC_ADDM = 4'd6,
    OPC_SUBM = 4'd7,
    OPC_MULM = 4'd8,
    OPC_DIVM = 4'd9,
    OPC_LDM  = 4'd10,
    OPC_STM  = 4'd11,
    OPC_JMP  = 4'd12,
    OPC_BNEG = 4'd13,
    OPC_BPOS = 4'd14,
    OPC_BZER = 4'd15
  } opc_e;

  typedef enum logic [2:0] {
    FN_NONE,
    FN_LOAD,
    FN_ADD,
    FN_SUB,
    FN_MUL,
    FN_DIV
  } alu_fn_e;

  typedef enum logic [1:0] {
    BR_ALWAYS,
    BR_NEG,
    BR_POS,
    BR_ZERO
  } br_cond_e;

  typedef struct packed {
    alu_fn_e  fn;
    logic     wr_acc;
    logic     upd_flags;
    logic     is_branch;
    br_cond_e cond;
  } op_ctl_t;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } sign_flags_t;

  function automatic op_ctl_t decode_op(input logic [OPC_W-1:0] op);
    op_ctl_t d;
    d.fn        = FN_NONE;
    d.wr_acc    = 1'b0;
    d.upd_flags = 1'b0;
    d.is_branch = 1'b0;
    d.cond      = BR_ALWAYS;
    case (op)
      OPC_LDI, OPC_LDM: begin
        d.fn = FN_LOAD; d.wr_acc = 1'b1; d.upd_flags = 1'b1;
      end
      OPC_ADDI, OPC_ADDM: begin
        d.fn = FN_ADD; d.wr_acc = 1'b1; d.upd_flags = 1'b1;
      end
      OPC_SUBI, OPC_SUBM: begin
        d.fn = FN_SUB; d.wr_acc = 1'b1; d.upd_flags = 1'b1;
      end
      OPC_MULI, OPC_MULM: begin
        d.fn = FN_MUL; d.wr_acc = 1'b1; d.upd_flags = 1'b1;
      end
      OPC_DIVI, OPC_DIVM: begin
        d.fn = FN_DIV; d.wr_acc = 1'b1; d.upd_flags = 1'b1;
      end
      OPC_JMP:  begin d.is_branch = 1'b1; d.cond = BR_ALWAYS; end
      OPC_BNEG: begin d.is_branch = 1'b1; d.cond = BR_NEG;    end
      OPC_BPOS: begin d.is_branch = 1'b1; d.cond = BR_POS;    end
      OPC_BZER: begin d.is_branch = 1'b1; d.cond = BR_ZERO;   end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/acc_alu_rst_sync.sv
module acc_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             cond_met_i,
  output logic             cap_en_o,
  output logic             exec_en_o,
  output op_ctl_t          ctl_o,
  output logic             done_o,
  output logic             br_taken_o
);

  typedef enum logic {ST_IDLE, ST_EXEC} state_e;

  state_e           state_q, state_d;
  logic [OPC_W-1:0] op_q, op_d;
  logic             done_q, done_d;
  logic             br_q, br_d;

  assign ctl_o     = decode_op(op_q);
  assign cap_en_o  = (state_q == ST_IDLE) && start_i && !clear_i;
  assign exec_en_o = (state_q == ST_EXEC) && !clear_i;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    done_d  = 1'b0;
    br_d    = 1'b0;
    if (clear_i) begin
      state_d = ST_IDLE;
      op_d    = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_d = ST_EXEC;
            op_d    = opcode_i;
          end
        end
        ST_EXEC: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          br_d    = ctl_o.is_branch && cond_met_i;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      done_q  <= 1'b0;
      br_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      done_q  <= done_d;
      br_q    <= br_d;
    end
  end

  assign done_o     = done_q;
  assign br_taken_o = br_q;

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: an operation in flight always returns to idle, ignoring start
  p_exec_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |=> (state_q == ST_IDLE));

  // R9: branch indication only together with completion
  p_branch_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_q |-> done_q);

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_en_i,
  input  logic              exec_en_i,
  input  op_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] result_o,
  output logic              div_by_zero_o
);

  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ALL1 = {DATA_W{1'b1}};

  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;

  logic              dvz, dvm1;
  logic [DATA_W-1:0] divisor_safe;
  logic signed [DATA_W-1:0] quot;
  logic [DATA_W-1:0] res;
  logic              acc_we;

  // divider guard: zero and minus one never reach the divide operator
  always_comb begin
    dvz          = (opnd_q == '0);
    dvm1         = (opnd_q == ALL1);
    divisor_safe = (dvz || dvm1) ? ONE : opnd_q;
    quot         = $signed(shadow_q) / $signed(divisor_safe);
  end

  always_comb begin
    case (ctl_i.fn)
      FN_LOAD: res = opnd_q;
      FN_ADD:  res = shadow_q + opnd_q;
      FN_SUB:  res = shadow_q - opnd_q;
      FN_MUL:  res = shadow_q * opnd_q;
      FN_DIV: begin
        if (dvz)       res = shadow_q;
        else if (dvm1) res = '0 - shadow_q;
        else           res = quot;
      end
      default: res = acc_q;
    endcase
  end

  assign div_by_zero_o = (ctl_i.fn == FN_DIV) && dvz;
  assign acc_we        = exec_en_i && ctl_i.wr_acc && !div_by_zero_o;
  assign result_o      = res;

  always_comb begin
    acc_d    = acc_q;
    shadow_d = shadow_q;
    opnd_d   = opnd_q;
    if (clear_i) begin
      acc_d    = '0;
      shadow_d = '0;
      opnd_d   = '0;
    end else begin
      if (cap_en_i) begin
        shadow_d = acc_q;
        opnd_d   = operand_i;
      end
      if (acc_we) acc_d = res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      shadow_q <= '0;
      opnd_q   <= '0;
    end else begin
      acc_q    <= acc_d;
      shadow_q <= shadow_d;
      opnd_q   <= opnd_d;
    end
  end

  assign acc_o = acc_q;

  // R8: accumulator only moves on a write or a clear
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en_i && !clear_i) |=> $stable(acc_q));

  // R6: zero divisor keeps the accumulator
  p_divzero_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en_i && div_by_zero_o) |=> (acc_q == $past(acc_q)));

  // R10: clear empties the accumulator
  p_clear_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (acc_q == '0));

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              exec_en_i,
  input  op_ctl_t           ctl_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              div_by_zero_i,
  output sign_flags_t       flags_o,
  output logic              cond_met_o
);

  sign_flags_t flags_q, flags_d, cls;
  logic        upd_en;

  always_comb begin
    cls.neg  = result_i[DATA_W-1];
    cls.zero = (result_i == '0);
    cls.pos  = !result_i[DATA_W-1] && (result_i != '0);
    if (div_by_zero_i) begin
      cls.neg  = 1'b0;
      cls.pos  = 1'b0;
      cls.zero = 1'b1;
    end
  end

  assign upd_en = exec_en_i && ctl_i.upd_flags;

  always_comb begin
    flags_d = flags_q;
    if (clear_i)     flags_d = '0;
    else if (upd_en) flags_d = cls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_comb begin
    case (ctl_i.cond)
      BR_ALWAYS: cond_met_o = 1'b1;
      BR_NEG:    cond_met_o = flags_q.neg;
      BR_POS:    cond_met_o = flags_q.pos;
      BR_ZERO:   cond_met_o = flags_q.zero;
      default:   cond_met_o = 1'b0;
    endcase
  end

  assign flags_o = flags_q;

  // R7: never more than one sign flag
  p_sign_onehot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_q));

  // R7: after an updating operation exactly one flag is set
  p_update_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clear_i) |=> $onehot(flags_q));

  // R8: flags hold when no update is requested
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !clear_i) |=> $stable(flags_q));

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [3:0]        opcode_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              flag_neg_o,
  output logic              flag_pos_o,
  output logic              flag_zero_o,
  output logic              done_o,
  output logic              br_taken_o
);

  logic              rst_sync_n;
  logic              cap_en, exec_en, cond_met, dvz;
  op_ctl_t           ctl;
  logic [DATA_W-1:0] result;
  sign_flags_t       flags;

  acc_alu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_alu_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .opcode_i   (opcode_i),
    .cond_met_i (cond_met),
    .cap_en_o   (cap_en),
    .exec_en_o  (exec_en),
    .ctl_o      (ctl),
    .done_o     (done_o),
    .br_taken_o (br_taken_o)
  );

  acc_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .clear_i       (clear_i),
    .cap_en_i      (cap_en),
    .exec_en_i     (exec_en),
    .ctl_i         (ctl),
    .operand_i     (operand_i),
    .acc_o         (acc_o),
    .result_o      (result),
    .div_by_zero_o (dvz)
  );

  acc_alu_flags #(.DATA_W(DATA_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .clear_i       (clear_i),
    .exec_en_i     (exec_en),
    .ctl_i         (ctl),
    .result_i      (result),
    .div_by_zero_i (dvz),
    .flags_o       (flags),
    .cond_met_o    (cond_met)
  );

  assign flag_neg_o  = flags.neg;
  assign flag_pos_o  = flags.pos;
  assign flag_zero_o = flags.zero;

  // R10: clear suppresses completion
  p_clear_nodone_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear_i |=> (!done_o && acc_o == '0));

endmodule

// File: tb/tb_acc_alu_core.sv
module tb_acc_alu_core;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n, start_i, clear_i;
  logic [3:0]   opcode_i;
  logic [W-1:0] operand_i;
  logic [W-1:0] acc_o;
  logic         flag_neg_o, flag_pos_o, flag_zero_o, done_o, br_taken_o;

  int vectors = 0;
  int errors  = 0;

  logic [W-1:0] m_acc;
  logic [2:0]   m_flags; // {neg,pos,zero}
  logic         m_br;

  always #5 clk = ~clk;

  acc_alu_core #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .opcode_i(opcode_i), .operand_i(operand_i), .acc_o(acc_o),
    .flag_neg_o(flag_neg_o), .flag_pos_o(flag_pos_o), .flag_zero_o(flag_zero_o),
    .done_o(done_o), .br_taken_o(br_taken_o)
  );

  function automatic logic [2:0] sign_of(input logic [W-1:0] v);
    if (v[W-1])     return 3'b100;
    else if (v == 0) return 3'b001;
    else            return 3'b010;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      1, 10:        return "R3/R7";
      2, 3, 6, 7:   return "R4/R7";
      4, 8:         return "R5/R7";
      5, 9:         return "R6/R7";
      12, 13, 14, 15: return "R9";
      default:      return "R8";
    endcase
  endfunction

  // reference model from the requirements
  task automatic model(input int op, input logic [W-1:0] b);
    longint sa, sb, r;
    sa = longint'($signed(m_acc));
    sb = longint'($signed(b));
    m_br = 1'b0;
    case (op)
      1, 10: begin m_acc = b; m_flags = sign_of(m_acc); end
      2, 6:  begin m_acc = W'(sa + sb); m_flags = sign_of(m_acc); end
      3, 7:  begin m_acc = W'(sa - sb); m_flags = sign_of(m_acc); end
      4, 8:  begin r = sa * sb; m_acc = r[W-1:0]; m_flags = sign_of(m_acc); end
      5, 9: begin
        if (sb == 0) m_flags = 3'b001;
        else begin
          if (sb == -1) r = -sa;
          else          r = sa / sb;
          m_acc   = r[W-1:0];
          m_flags = sign_of(m_acc);
        end
      end
      12: m_br = 1'b1;
      13: m_br = m_flags[2];
      14: m_br = m_flags[1];
      15: m_br = m_flags[0];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic exp_done);
    logic [2:0] f;
    f = {flag_neg_o, flag_pos_o, flag_zero_o};
    vectors++;
    if (acc_o !== m_acc || f !== m_flags || br_taken_o !== (m_br && exp_done) ||
        done_o !== exp_done) begin
      errors++;
      $display("FAIL %s: acc=%h flags=%b br=%b done=%b expected acc=%h flags=%b br=%b done=%b",
               tag, acc_o, f, br_taken_o, done_o, m_acc, m_flags, m_br && exp_done, exp_done);
    end
  endtask

  task automatic run_op(input int op, input logic [W-1:0] b);
    start_i   = 1'b1;
    opcode_i  = 4'(op);
    operand_i = b;
    @(negedge clk);
    start_i   = 1'b0;
    operand_i = '1;
    @(negedge clk);
    model(op, b);
    check(tag_of(op), 1'b1);
  endtask

  logic [W-1:0] vals [12];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    vals = '{32'd0, 32'd1, 32'hFFFFFFFF, 32'd2, 32'hFFFFFFFE, 32'd7, 32'hFFFFFFF9,
             32'd100, 32'hFFFFFF9C, 32'h7FFFFFFF, 32'h80000000, 32'd12345};
    rst_n = 1'b0; start_i = 1'b0; clear_i = 1'b0; opcode_i = '0; operand_i = '0;
    m_acc = '0; m_flags = '0; m_br = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 1'b0);

    // R3..R9 sweep over value pairs and all arithmetic opcodes
    for (int ia = 0; ia < 12; ia++) begin
      for (int ib = 0; ib < 12; ib++) begin
        for (int op = 2; op <= 9; op++) begin
          run_op((ia % 2 == 0) ? 1 : 10, vals[ia]);
          run_op(op, vals[ib]);
          for (int bo = 12; bo <= 15; bo++) run_op(bo, vals[ib]);
          run_op(11, vals[ib]);
          run_op(0, vals[ib]);
        end
      end
    end

    // R2: done falls after one cycle, nothing changes while idle
    run_op(1, 32'd42);
    @(negedge clk);
    check("R2 done pulse ends", 1'b0);

    // R2: second start during the busy cycle is ignored
    start_i = 1'b1; opcode_i = 4'd2; operand_i = 32'd5;
    @(negedge clk);
    opcode_i = 4'd1; operand_i = 32'd999;
    @(negedge clk);
    start_i = 1'b0;
    model(2, 32'd5);
    check("R2 busy start ignored", 1'b1);
    @(negedge clk);
    check("R2 no second done", 1'b0);

    // R6: explicit divide corner values
    run_op(1, 32'hFFFFFFF9);
    run_op(5, 32'd2);          // -7/2 -> -3
    run_op(1, 32'h80000000);
    run_op(9, 32'hFFFFFFFF);   // min/-1 -> min
    run_op(5, 32'd0);          // divide by zero

    // R10: clear while idle
    run_op(1, 32'd77);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    m_acc = '0; m_flags = '0; m_br = 1'b0;
    check("R10 clear idle", 1'b0);

    // R10: clear aborts an operation in flight
    run_op(1, 32'hFFFFFF00);
    start_i = 1'b1; opcode_i = 4'd2; operand_i = 32'd3;
    @(negedge clk);
    start_i = 1'b0; clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    m_acc = '0; m_flags = '0; m_br = 1'b0;
    check("R10 clear aborts", 1'b0);
    @(negedge clk);
    check("R10 no late done", 1'b0);

    // R10: clear wins over start on the same edge
    start_i = 1'b1; clear_i = 1'b1; opcode_i = 4'd1; operand_i = 32'd9;
    @(negedge clk);
    start_i = 1'b0; clear_i = 1'b0;
    @(negedge clk);
    check("R10 clear over start", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule